// File: doc/BRIEF.md
# Receiver Operating Mode Controller

This block sets the operating mode of a low-power radio receiver. Software writes one 8-bit mode register. Two bits of that register are decoded: `mode_sel` (bit 0) and `slave_en` (bit 1). After reset the controller runs a fixed boot sequence with a general init phase and then a receiver-init phase. It then settles in one of three modes:

- **Sleep**: the receiver is idle.
- **Slave run**: the receiver is on all the time.
- **Self-polling**: the receiver wakes up at regular intervals to search for a wake-up criterion.

In self-polling, a wake-up criterion seen while the receiver is listening moves the controller into a polling-run state. The receiver stays on in that state until the activity timeout input fires. The controller then goes back to periodic polling.

A change of `mode_sel` sends the controller back through both init phases before it enters the new mode. A change of `slave_en` alone moves directly between sleep and slave run. The block reports the current state as a 3-bit code and drives a receiver-enable output. The analog front end and the pattern detector that raises the wake-up flag are outside this block.

Top module: `rxm_mode_ctrl`

## Requirements
- R1: The mode register sits at address `REG_ADDR` (default 0x02) and resets to 0x40. A write with `wr_en_i` high loads the register on the same clock edge, and the state machine responds on the following edge. Writes to any other address leave the register and the state unchanged.
- R2: While reset is asserted, and after it is released, the state code is INIT (0). INIT lasts `INIT_CYC` cycles. RXINIT (1) then lasts `RXI_CYC` cycles. The state code never leaves the range 0 to 5.
- R3: When RXINIT ends, the next state depends on the register:
  - `mode_sel`=1 selects POLL (4).
  - `mode_sel`=0 with `slave_en`=1 selects SLAVE (3).
  - `mode_sel`=0 with `slave_en`=0 selects SLEEP (2).
- R4: With `mode_sel`=0, setting `slave_en` moves SLEEP to SLAVE, and clearing it moves SLAVE to SLEEP. Neither move passes through INIT.
- R5: While `mode_sel`=1, the value of `slave_en` has no effect on the state or on `rx_en_o`.
- R6: On each entry to POLL, a period of `POLL_OFF`+`POLL_ON` cycles restarts. In POLL, `rx_en_o` is high only during the last `POLL_ON` cycles of each period.
- R7: In POLL, `wuc_found_i` high while `rx_en_o` is high moves the state to PRUN (5) on the next edge. `wuc_found_i` seen while `rx_en_o` is low is ignored.
- R8: PRUN holds while `timeout_i` is 0. `timeout_i`=1 returns the state to POLL on the next edge.
- R9: A change of `mode_sel` while the controller is in SLEEP, SLAVE, POLL or PRUN moves the state to INIT on the next edge. The full boot sequence of R2 and R3 then follows.
- R10: `rx_en_o` is 1 in SLAVE and PRUN, and 0 in INIT, RXINIT and SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| wuc_found_i | input | 1 | Wake-up criterion found |
| timeout_i | input | 1 | Activity timeout flag |
| state_o | output | 3 | Current state code |
| rx_en_o | output | 1 | Receiver enable |

## Verification
The bench targets the following corner cases:

- **Wake-up at the off/on boundary of the polling period.** The wake-up flag is held high through the whole off window. A design that decodes the window one cycle early or late would enter PRUN at the wrong cycle.
- **Writes of `slave_en` while `mode_sel` is 1.** A controller that lets `slave_en` override the mode would drop out of polling.
- **Mode changes from each settled state.** A controller that skips the init states, or restarts them with a stale count, shows a wrong state code during the boot sequence.
- **Writes to a neighbouring address.** These must change nothing.

Random writes, wake-up flags and timeouts are compared against a cycle model on every cycle.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,
    ST_RXINIT = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_SLAVE  = 3'd3,
    ST_POLL   = 3'd4,
    ST_PRUN   = 3'd5
  } rxm_state_e;

  localparam int unsigned MSEL_BIT = 0;
  localparam int unsigned SLEN_BIT = 1;
endpackage

// File: rtl/rxm_cfg_reg.sv
module rxm_cfg_reg #(
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h02,
  parameter logic [DATA_W-1:0]    REG_RST  = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] cfg_o
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_o <= REG_RST;
    else if (hit) cfg_o <= wr_data_i;
  end
endmodule

// File: rtl/rxm_dwell_ctr.sv
module rxm_dwell_ctr
  import rxm_pkg::*;
#(
  parameter int unsigned INIT_CYC = 4,
  parameter int unsigned RXI_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rxm_state_e state_i,
  input  logic       st_chg_i,
  output logic       done_o
);
  localparam int unsigned MAXC = (INIT_CYC > RXI_CYC) ? INIT_CYC : RXI_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] RXI_LAST  = CW'(RXI_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = (state_i == ST_INIT) || (state_i == ST_RXINIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (st_chg_i) cnt_q <= '0;
    else if (counting) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (state_i)
      ST_INIT:   done_o = (cnt_q == INIT_LAST);
      ST_RXINIT: done_o = (cnt_q == RXI_LAST);
      default:   done_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxm_poll_tmr.sv
module rxm_poll_tmr #(
  parameter int unsigned POLL_OFF = 6,
  parameter int unsigned POLL_ON  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic on_win_o
);
  localparam int unsigned PER = POLL_OFF + POLL_ON;
  localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [PW-1:0] PER_LAST = PW'(PER - 1);
  localparam logic [PW-1:0] ON_START = PW'(POLL_OFF);

  logic [PW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (!run_i)            tmr_q <= '0;
    else if (tmr_q == PER_LAST) tmr_q <= '0;
    else                        tmr_q <= tmr_q + 1'b1;
  end

  assign on_win_o = run_i && (tmr_q >= ON_START);
endmodule

// File: rtl/rxm_mode_ctrl.sv
module rxm_mode_ctrl
  import rxm_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02,
  parameter logic [7:0]        REG_RST  = 8'h40,
  parameter int unsigned       INIT_CYC = 4,
  parameter int unsigned       RXI_CYC  = 3,
  parameter int unsigned       POLL_OFF = 6,
  parameter int unsigned       POLL_ON  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wuc_found_i,
  input  logic              timeout_i,
  output logic [2:0]        state_o,
  output logic              rx_en_o
);
  logic [7:0] cfg_q;
  logic       msel, slen;
  rxm_state_e state_q, state_d;
  logic       dwell_done, on_win, st_chg;

  rxm_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(8), .REG_ADDR(REG_ADDR), .REG_RST(REG_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .cfg_o(cfg_q)
  );

  assign msel = cfg_q[MSEL_BIT];
  assign slen = cfg_q[SLEN_BIT];

  rxm_dwell_ctr #(.INIT_CYC(INIT_CYC), .RXI_CYC(RXI_CYC)) u_dwell (
    .clk_i, .rst_ni, .state_i(state_q), .st_chg_i(st_chg), .done_o(dwell_done)
  );

  rxm_poll_tmr #(.POLL_OFF(POLL_OFF), .POLL_ON(POLL_ON)) u_ptmr (
    .clk_i, .rst_ni, .run_i(state_q == ST_POLL), .on_win_o(on_win)
  );

  // mode_sel mismatch with the settled mode forces a full re-init
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:   if (dwell_done) state_d = ST_RXINIT;
      ST_RXINIT: if (dwell_done) state_d = msel ? ST_POLL : (slen ? ST_SLAVE : ST_SLEEP);
      ST_SLEEP,
      ST_SLAVE:  state_d = msel ? ST_INIT : (slen ? ST_SLAVE : ST_SLEEP);
      ST_POLL:   if (!msel) state_d = ST_INIT;
                 else if (on_win && wuc_found_i) state_d = ST_PRUN;
      ST_PRUN:   if (!msel) state_d = ST_INIT;
                 else if (timeout_i) state_d = ST_POLL;
      default:   state_d = ST_INIT;
    endcase
  end

  assign st_chg = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign rx_en_o = (state_q == ST_SLAVE) || (state_q == ST_PRUN) || on_win;
endmodule

// File: rtl/rxm_mode_ctrl_chk.sv
module rxm_mode_ctrl_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              wuc_found_i,
  input logic              timeout_i,
  input logic [2:0]        state_o,
  input logic              rx_en_o,
  input logic [7:0]        cfg_q
);
  AST_REG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_ADDR) |=> (cfg_q == $past(wr_data_i))); // R1
  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5); // R2
  AST_SLEEP_TO_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && cfg_q[1:0] == 2'b10) |=> state_o == 3'd3); // R4
  AST_SLEN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd4 || state_o == 3'd5) && cfg_q[0]) |=> (state_o == 3'd4 || state_o == 3'd5)); // R5
  AST_WAKE_OFF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !rx_en_o && cfg_q[0]) |=> state_o == 3'd4); // R7
  AST_WAKE_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && rx_en_o && wuc_found_i && cfg_q[0]) |=> state_o == 3'd5); // R7
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !timeout_i && cfg_q[0]) |=> state_o == 3'd5); // R8
  AST_RUN_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && timeout_i && cfg_q[0]) |=> (state_o == 3'd4 && !rx_en_o)); // R8
  AST_MODE_REINIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd2 || state_o == 3'd3) && cfg_q[0]) |=> state_o == 3'd0); // R9
  AST_RX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 3'd2) |-> !rx_en_o); // R10
  AST_RX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 || state_o == 3'd5) |-> rx_en_o); // R10
endmodule

bind rxm_mode_ctrl rxm_mode_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wuc_found_i(wuc_found_i), .timeout_i(timeout_i),
  .state_o(state_o), .rx_en_o(rx_en_o), .cfg_q(cfg_q)
);

// File: tb/rxm_mode_ctrl_test.sv
`timescale 1ns/1ps
module rxm_mode_ctrl_test;
  localparam int INIT_CYC = 4;
  localparam int RXI_CYC  = 3;
  localparam int POLL_OFF = 6;
  localparam int POLL_ON  = 3;
  localparam int S_INIT = 0, S_RXI = 1, S_SLEEP = 2, S_SLAVE = 3, S_POLL = 4, S_PRUN = 5;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wuc = 0, tmo = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [2:0] state;
  logic       rx_en;
  int         checks = 0, errors = 0;
  bit         cmp_en = 0;

  always #10 clk = ~clk;

  rxm_mode_ctrl #(.ADDR_W(8), .REG_ADDR(8'h02), .REG_RST(8'h40), .INIT_CYC(INIT_CYC),
    .RXI_CYC(RXI_CYC), .POLL_OFF(POLL_OFF), .POLL_ON(POLL_ON)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wuc_found_i(wuc), .timeout_i(tmo), .state_o(state), .rx_en_o(rx_en));

  // cycle model built from the requirements
  logic [7:0] m_reg;
  int m_state, m_cnt, m_tmr;

  function automatic bit m_on(int st, int t);
    return st == S_POLL && t >= POLL_OFF;
  endfunction

  function automatic bit m_rx(int st, int t);
    return st == S_SLAVE || st == S_PRUN || m_on(st, t);
  endfunction

  function automatic int m_next(int st, int c, int t, logic [7:0] r, bit w, bit to);
    case (st)
      S_INIT:  return (c == INIT_CYC-1) ? S_RXI : S_INIT;
      S_RXI:   return (c != RXI_CYC-1) ? S_RXI : (r[0] ? S_POLL : (r[1] ? S_SLAVE : S_SLEEP));
      S_SLEEP, S_SLAVE: return r[0] ? S_INIT : (r[1] ? S_SLAVE : S_SLEEP);
      S_POLL:  return !r[0] ? S_INIT : ((m_on(st, t) && w) ? S_PRUN : S_POLL);
      default: return !r[0] ? S_INIT : (to ? S_POLL : S_PRUN);
    endcase
  endfunction

  function automatic string req_of(int st);
    case (st)
      S_INIT, S_RXI:    return "R2";
      S_SLEEP, S_SLAVE: return "R4";
      S_POLL:           return "R7";
      default:          return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h40; m_state = S_INIT; m_cnt = 0; m_tmr = 0;
    end else begin
      int nx;
      nx = m_next(m_state, m_cnt, m_tmr, m_reg, wuc, tmo);
      if (m_state != S_POLL) m_tmr = 0;
      else m_tmr = (m_tmr == POLL_OFF+POLL_ON-1) ? 0 : m_tmr + 1;
      if (nx != m_state) m_cnt = 0;
      else if (m_state <= S_RXI) m_cnt = m_cnt + 1;
      m_state = nx;
      if (wr_en && wr_addr == 8'h02) m_reg = wr_data;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_en) begin
    chk(state == 3'(m_state), req_of(m_state), state, m_state);
    chk(rx_en == m_rx(m_state, m_tmr), "R10", rx_en, m_rx(m_state, m_tmr));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    cyc(2);
    chk(state == 3'(S_INIT), "R2", state, S_INIT);
    chk(rx_en == 0, "R10", rx_en, 0);
    @(negedge clk); rst_n = 1; cmp_en = 1;
    chk(state == 3'(S_INIT), "R2", state, S_INIT);
    cyc(INIT_CYC);
    chk(state == 3'(S_RXI), "R2", state, S_RXI);
    cyc(RXI_CYC);
    chk(state == 3'(S_SLEEP), "R3", state, S_SLEEP);
    // neighbouring address must be ignored
    wr(8'h03, 8'h03); cyc(2);
    chk(state == 3'(S_SLEEP), "R1", state, S_SLEEP);
    wr(8'h02, 8'h02); cyc(1);
    chk(state == 3'(S_SLAVE) && rx_en, "R4", state, S_SLAVE);
    wr(8'h02, 8'h00); cyc(1);
    chk(state == 3'(S_SLEEP) && !rx_en, "R4", state, S_SLEEP);
    wr(8'h02, 8'h02); cyc(1);
    // switch to polling: full re-init
    wr(8'h02, 8'h03); cyc(1);
    chk(state == 3'(S_INIT), "R9", state, S_INIT);
    cyc(INIT_CYC + RXI_CYC);
    chk(state == 3'(S_POLL) && !rx_en, "R3", state, S_POLL);
    wuc = 1;
    cyc(POLL_OFF);
    chk(state == 3'(S_POLL), "R7", state, S_POLL);
    chk(rx_en == 1, "R6", rx_en, 1);
    cyc(1);
    chk(state == 3'(S_PRUN), "R7", state, S_PRUN);
    wuc = 0;
    wr(8'h02, 8'h01); cyc(2);
    chk(state == 3'(S_PRUN) && rx_en, "R5", state, S_PRUN);
    tmo = 1; cyc(1); tmo = 0;
    chk(state == 3'(S_POLL) && !rx_en, "R8", state, S_POLL);
    wr(8'h02, 8'h02); cyc(1);
    chk(state == 3'(S_INIT), "R9", state, S_INIT);
    cyc(INIT_CYC + RXI_CYC);
    chk(state == 3'(S_SLAVE), "R3", state, S_SLAVE);
    // random phase, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wuc = ($urandom % 100) < 30;
      tmo = ($urandom % 100) < 10;
      wr_en = ($urandom % 100) < 4;
      wr_addr = ($urandom % 4 == 0) ? 8'h03 : 8'h02;
      wr_data = 8'($urandom);
    end
    @(negedge clk); wr_en = 0; wuc = 0; tmo = 0;
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule